// File: doc/BRIEF.md
# Segment-Mapped Address Translation Front End

This combinational block sits in front of a paged translation buffer and decides, for every request, which of three routes a 32-bit virtual address takes. When translation is switched off in the global configuration word, the address passes through untouched with full permissions. When translation is on, a kernel-mode access whose segment (the top address nibble) is marked in a 16-bit segment map has that nibble replaced by a 4-bit base picked from two packed 32-bit base registers. Every other access goes to the paged buffer, and the buffer's answer is forwarded unchanged to the outputs.

The route is an enumerated value with three members. ROUTE_BYPASS is chosen when translation is off. ROUTE_SEGMENT is chosen when translation is on, the access is not in user mode and the segment's map bit is set. ROUTE_PAGED covers every other case. These are the block's only states. The choice is made fresh from the inputs on every request, so no transition depends on history: any route can follow any other as the inputs change.

Top module: `seg_xlate_front`

## Requirements
- R1: Translation is on exactly when bit 2 or bit 3 of `gcfg_i` is set. No other bit of that word has any effect.
- R2: When translation is off and `req_i` is 1, `paddr_o` equals `vaddr_i`, `perm_o` is 3'b111, `miss_o` is 0, `xl_valid_o` is 1 and `tlb_req_o` is 0.
- R3: The segment number is `vaddr_i[31:28]`. A request is segment-mapped when translation is on, `user_i` is 0 and bit [segment] of `mcfg_i` is set.
- R4: Segments 0 to 7 take their base nibble from `kbase_lo_i` and segments 8 to 15 take it from `kbase_hi_i`. In both cases the nibble is bits [4*(seg mod 8)+3 : 4*(seg mod 8)].
- R5: On a segment-mapped request, `paddr_o` is {base nibble, `vaddr_i[27:0]`}, `perm_o` is 3'b111, `miss_o` is 0, `xl_valid_o` is 1 and `tlb_req_o` is 0.
- R6: When translation is on, a user-mode request always takes the paged route, whatever `mcfg_i` holds.
- R7: On the paged route, `tlb_req_o` equals `req_i`. The outputs `paddr_o`, `perm_o`, `miss_o` and `xl_valid_o` copy `tlb_paddr_i`, `tlb_perm_i`, `tlb_miss_i` and `tlb_valid_i` unchanged.
- R8: While `req_i` is 0, `xl_valid_o` and `tlb_req_o` are both 0 on every route.
- R9: Permission bit 0 means read, bit 1 means write and bit 2 means execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | 1 | Translation request for this cycle |
| vaddr_i | input | 32 | Virtual address |
| user_i | input | 1 | 1 for a user-mode access, 0 for kernel |
| gcfg_i | input | 32 | Global configuration word; bits 2 and 3 switch translation on |
| mcfg_i | input | 32 | Translation configuration word; bits 15:0 hold the segment map |
| kbase_lo_i | input | 32 | Packed base nibbles for segments 0 to 7 |
| kbase_hi_i | input | 32 | Packed base nibbles for segments 8 to 15 |
| tlb_req_o | output | 1 | Lookup request sent to the paged buffer |
| tlb_valid_i | input | 1 | Paged buffer result is valid |
| tlb_paddr_i | input | 32 | Physical address from the paged buffer |
| tlb_perm_i | input | 3 | Permissions from the paged buffer |
| tlb_miss_i | input | 1 | Miss or fault from the paged buffer |
| xl_valid_o | output | 1 | Translation result valid |
| paddr_o | output | 32 | Physical address |
| perm_o | output | 3 | Permissions: execute, write, read (bit 2 to bit 0) |
| miss_o | output | 1 | Translation failed |

## Verification
The block holds no state, so a wrong route decision or a wrong nibble select shows up at the outputs as soon as the inputs settle. It appears in the same request as a wrong upper address nibble, permissions that are too wide, or a lookup request that goes missing or appears when it should not. The sweep covers every segment with both privilege levels, several segment maps and enable words, and both base registers. A misplaced nibble index or a mixed-up low/high register therefore shows up on at least one segment.

// File: rtl/sxf_pkg.sv
package sxf_pkg;
    localparam int ADDR_W = 32;
    localparam int SEG_W  = 4;
    localparam int PERM_W = 3;
    localparam logic [PERM_W-1:0] PERM_ALL = '1;

    typedef enum logic [1:0] {
        ROUTE_BYPASS  = 2'd0,
        ROUTE_SEGMENT = 2'd1,
        ROUTE_PAGED   = 2'd2
    } route_t;
endpackage

// File: rtl/sxf_route_dec.sv
module sxf_route_dec
    import sxf_pkg::*;
#(
    parameter int CFG_W = 32,
    parameter logic [CFG_W-1:0] EN_MASK = 32'h0000_000C,
    parameter int SW = 4
) (
    input  logic [SW-1:0]    seg_i,
    input  logic             user_i,
    input  logic [CFG_W-1:0] gcfg_i,
    input  logic [CFG_W-1:0] mcfg_i,
    output route_t           route_o
);
    logic xl_on;
    logic seg_hit;

    always_comb begin
        xl_on   = |(gcfg_i & EN_MASK);
        seg_hit = mcfg_i[seg_i];
        if (!xl_on)
            route_o = ROUTE_BYPASS;
        else if (!user_i && seg_hit)
            route_o = ROUTE_SEGMENT;
        else
            route_o = ROUTE_PAGED;

        // R1: enable bits clear means bypass, set means never bypass
        p_enable_r1: assert (((gcfg_i & EN_MASK) == '0) == (route_o == ROUTE_BYPASS));
        // R6: user mode never reaches the segment route
        p_user_paged_r6: assert (!(user_i && route_o == ROUTE_SEGMENT));
    end
endmodule

// File: rtl/sxf_seg_base.sv
module sxf_seg_base #(
    parameter int SW = 4
) (
    input  logic [SW-1:0]                   seg_i,
    input  logic [SW*(2**(SW-1))-1:0]       kbase_lo_i,
    input  logic [SW*(2**(SW-1))-1:0]       kbase_hi_i,
    output logic [SW-1:0]                   base_o
);
    localparam int HALF = 2**(SW-1);

    logic [SW-1:0] lo_nib [HALF];
    logic [SW-1:0] hi_nib [HALF];

    genvar g;
    generate
        for (g = 0; g < HALF; g++) begin : g_nib
            assign lo_nib[g] = kbase_lo_i[g*SW +: SW];
            assign hi_nib[g] = kbase_hi_i[g*SW +: SW];
        end
    endgenerate

    always_comb begin
        if (seg_i[SW-1])
            base_o = hi_nib[seg_i[SW-2:0]];
        else
            base_o = lo_nib[seg_i[SW-2:0]];
        // R4: segment zero always draws from the low register bottom nibble
        if (seg_i == '0)
            p_seg0_base_r4: assert (base_o == kbase_lo_i[SW-1:0]);
    end
endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
    import sxf_pkg::*;
(
    input  logic              req_i,
    input  logic [31:0]       vaddr_i,
    input  logic              user_i,
    input  logic [31:0]       gcfg_i,
    input  logic [31:0]       mcfg_i,
    input  logic [31:0]       kbase_lo_i,
    input  logic [31:0]       kbase_hi_i,
    output logic              tlb_req_o,
    input  logic              tlb_valid_i,
    input  logic [31:0]       tlb_paddr_i,
    input  logic [2:0]        tlb_perm_i,
    input  logic              tlb_miss_i,
    output logic              xl_valid_o,
    output logic [31:0]       paddr_o,
    output logic [2:0]        perm_o,
    output logic              miss_o
);
    localparam int OFF_W = ADDR_W - SEG_W;

    route_t          route;
    logic [SEG_W-1:0] base_nib;
    logic [SEG_W-1:0] seg;

    assign seg = vaddr_i[ADDR_W-1 -: SEG_W];

    sxf_route_dec #(.CFG_W(32), .EN_MASK(32'h0000_000C), .SW(SEG_W)) u_route (
        .seg_i   (seg),
        .user_i  (user_i),
        .gcfg_i  (gcfg_i),
        .mcfg_i  (mcfg_i),
        .route_o (route)
    );

    sxf_seg_base #(.SW(SEG_W)) u_base (
        .seg_i      (seg),
        .kbase_lo_i (kbase_lo_i),
        .kbase_hi_i (kbase_hi_i),
        .base_o     (base_nib)
    );

    always_comb begin
        tlb_req_o  = 1'b0;
        xl_valid_o = req_i;
        paddr_o    = vaddr_i;
        perm_o     = PERM_ALL;
        miss_o     = 1'b0;
        unique case (route)
            ROUTE_BYPASS: begin
                paddr_o = vaddr_i;
            end
            ROUTE_SEGMENT: begin
                paddr_o = {base_nib, vaddr_i[OFF_W-1:0]};
            end
            ROUTE_PAGED: begin
                tlb_req_o  = req_i;
                xl_valid_o = req_i & tlb_valid_i;
                paddr_o    = tlb_paddr_i;
                perm_o     = tlb_perm_i;
                miss_o     = tlb_miss_i;
            end
            default: begin
                xl_valid_o = 1'b0;
            end
        endcase

        // R8: idle requests produce nothing
        if (!req_i)
            p_idle_r8: assert (!xl_valid_o && !tlb_req_o);
        // R2/R5: non-paged routes never miss, never narrow rights, never query
        if (route != ROUTE_PAGED)
            p_direct_full_r5: assert (perm_o == 3'b111 && !miss_o && !tlb_req_o);
        // R5: offset bits survive segment relocation
        if (route == ROUTE_SEGMENT)
            p_offset_kept_r5: assert (paddr_o[OFF_W-1:0] == vaddr_i[OFF_W-1:0]);
        // R7: paged route copies the buffer result
        if (route == ROUTE_PAGED)
            p_paged_fwd_r7: assert (paddr_o == tlb_paddr_i && miss_o == tlb_miss_i);
    end
endmodule

// File: tb/sim_seg_xlate_front.sv
module sim_seg_xlate_front;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        req, user, tlb_valid, tlb_miss, tlb_req;
    logic [31:0] vaddr, gcfg, mcfg, klo, khi, tlb_paddr;
    logic [2:0]  tlb_perm;
    logic        xl_valid, miss;
    logic [31:0] paddr;
    logic [2:0]  perm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    seg_xlate_front u0 (
        .req_i(req), .vaddr_i(vaddr), .user_i(user), .gcfg_i(gcfg),
        .mcfg_i(mcfg), .kbase_lo_i(klo), .kbase_hi_i(khi),
        .tlb_req_o(tlb_req), .tlb_valid_i(tlb_valid), .tlb_paddr_i(tlb_paddr),
        .tlb_perm_i(tlb_perm), .tlb_miss_i(tlb_miss),
        .xl_valid_o(xl_valid), .paddr_o(paddr), .perm_o(perm), .miss_o(miss)
    );

    // stub paged buffer: result derived from the address
    always_comb begin
        tlb_paddr = ~vaddr ^ 32'h0000_1357;
        tlb_perm  = vaddr[2:0];
        tlb_miss  = vaddr[3];
    end

    task automatic chk(input string req_tag, input logic [37:0] act, input logic [37:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h (valid,treq,miss,perm,paddr) va=%h u=%0b g=%h m=%h",
                     req_tag, act, exp, vaddr, user, gcfg, mcfg);
        end
    endtask

    task automatic apply_and_check();
        logic        on, segmap;
        logic [3:0]  sg, nib;
        logic [37:0] exp, act;
        string       tag;
        #1;
        sg     = vaddr[31:28];
        on     = gcfg[2] | gcfg[3];
        segmap = mcfg[sg];
        nib    = (sg < 8) ? 4'((klo >> (4*sg)) & 32'hF) : 4'((khi >> (4*(sg-8))) & 32'hF);
        if (!on) begin
            tag = "R1/R2/R9 bypass";
            exp = {req, 1'b0, 1'b0, 3'b111, vaddr};
        end else if (!user && segmap) begin
            tag = "R3/R4/R5 segment";
            exp = {req, 1'b0, 1'b0, 3'b111, nib, vaddr[27:0]};
        end else begin
            tag = user ? "R6/R7 user paged" : "R7 paged";
            exp = {req & tlb_valid, req, tlb_miss, tlb_perm, tlb_paddr};
        end
        act = {xl_valid, tlb_req, miss, perm, paddr};
        if (!req) begin
            tag = "R8 idle";
            chk(tag, {act[37:36], 36'h0}, {2'b00, 36'h0});
        end else begin
            chk(tag, act, exp);
        end
        #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] gset [6];
        logic [31:0] mset [4];
        gset[0] = 32'h0; gset[1] = 32'h4; gset[2] = 32'h8; gset[3] = 32'hC;
        gset[4] = 32'hFFFF_FFF3; gset[5] = 32'h0000_0010;
        mset[0] = 32'h0000_0000; mset[1] = 32'h0000_FFFF;
        mset[2] = 32'h0000_A5C3; mset[3] = 32'hFFFF_0000;
        klo = 32'h7654_3210 ^ 32'h1B2D_4E8F;
        khi = 32'hFEDC_BA98 ^ 32'h2468_ACE1;
        req = 0; user = 0; gcfg = 0; mcfg = 0; vaddr = 0; tlb_valid = 1;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        // reset/idle state: R8
        apply_and_check();
        for (int gi = 0; gi < 6; gi++)
            for (int mi = 0; mi < 4; mi++)
                for (int s = 0; s < 16; s++)
                    for (int u = 0; u < 2; u++)
                        for (int rq = 0; rq < 2; rq++)
                            for (int tv = 0; tv < 2; tv++) begin
                                gcfg = gset[gi]; mcfg = mset[mi];
                                user = u[0]; req = rq[0]; tlb_valid = tv[0];
                                vaddr = {s[3:0], 28'h5A3_C6E9 ^ 28'(s * 32'h0111_1111) ^ 28'(gi * 5 + mi)};
                                apply_and_check();
                            end
        // base register swap shows low/high selection: R4
        klo = 32'h8888_8888; khi = 32'h1111_1111;
        gcfg = 32'h4; mcfg = 32'hFFFF; user = 0; req = 1;
        for (int s = 0; s < 16; s++) begin
            vaddr = {s[3:0], 28'h0AB_CDEF};
            apply_and_check();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule